// File: doc/BRIEF.md
# Ripple-Carry Bit-Slice ALU with Signed Compare

This block is a combinational arithmetic and logic unit assembled from one-bit slices. Every slice receives one bit of each operand and performs a bitwise AND, a bitwise OR and a full-adder sum. It then passes on one of these, or a separate "less" input, according to a two-bit function select. A single invert control complements the second operand on its way into every slice and also supplies the carry into the lowest slice. With the invert control high, the adder therefore forms the two's-complement difference.

The most-significant slice also produces a signed overflow indication and a "set" bit. The set bit is the true sign of the sum or difference, corrected for overflow. It is routed back into the less input of bit 0, and the less inputs of all other bits are tied low. A signed set-less-than therefore costs no extra comparator. A zero flag reports an all-zero result. The unit sits in a processor datapath, where a control decoder drives the function select and the invert control for each instruction.

Top module: `slt_alu`

## Requirements
- R1: With function select 0, the result is the bitwise AND of operand A and the effective B. The effective B is B complemented when the invert control is 1, and B unchanged otherwise.
- R2: With function select 1, the result is the bitwise OR of A and the effective B.
- R3: With function select 2 and the invert control 0, the result is A + B modulo 2^WIDTH.
- R4: With function select 2 and the invert control 1, the result is A - B modulo 2^WIDTH, formed as A + ~B + 1.
- R5: The invert control complements B for the logical functions as well, so select 0 with invert 1 yields A AND NOT B.
- R6: The zero flag is 1 exactly when every result bit is 0, whatever function is selected.
- R7: The overflow flag is 1 when the signed adder output (A plus effective B plus carry-in) cannot be represented in WIDTH bits. It is driven from the adder for every function select.
- R8: With function select 3 and the invert control 1, the result is 1 when A < B as signed numbers and 0 otherwise. This holds even when the internal subtraction overflows.
- R9: With function select 3, result bits 1 to WIDTH-1 are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| op_i | input | 2 | Function select: 0 AND, 1 OR, 2 adder, 3 less |
| b_inv_i | input | 1 | Complements B into every slice and is the carry into bit 0 |
| result_o | output | WIDTH | Selected result |
| zero_o | output | 1 | High when result_o is all zeros |
| ovf_o | output | 1 | Signed overflow of the adder path |

## Verification
Every output of the unit is combinational. Each result is due in the same clock cycle in which the operands and controls are applied, after the ripple carry and the set feedback have settled. The bench changes inputs just after a falling edge and samples all three outputs one nanosecond later, well before the next rising edge. Each comparison therefore sees settled values from a single stimulus. The corner vectors include the most-negative and most-positive operands, where the subtraction overflows and the compare must still give the correct sign.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  typedef enum logic [1:0] {
    FN_AND  = 2'd0,
    FN_OR   = 2'd1,
    FN_SUM  = 2'd2,
    FN_LESS = 2'd3
  } alu_fn_e;

  // sum bit of a one-bit full adder
  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  // carry out of a one-bit full adder (majority of the three inputs)
  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (x & c) | (y & c);
  endfunction

  // four-way pick by function select
  function automatic logic fn_pick(input alu_fn_e fn, input logic v_and,
                                   input logic v_or, input logic v_sum,
                                   input logic v_less);
    logic r;
    unique case (fn)
      FN_AND:  r = v_and;
      FN_OR:   r = v_or;
      FN_SUM:  r = v_sum;
      default: r = v_less;
    endcase
    return r;
  endfunction

  // signed overflow from the carries around the top bit
  function automatic logic top_overflow(input logic c_in, input logic c_out);
    return c_in ^ c_out;
  endfunction

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_slice_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  logic    b_inv_i,
  input  logic    cin_i,
  input  logic    less_i,
  input  alu_fn_e fn_i,
  output logic    res_o,
  output logic    sum_o,
  output logic    cout_o
);

  logic b_eff_w;
  logic and_w;
  logic or_w;

  assign b_eff_w = b_i ^ b_inv_i;
  assign and_w   = a_i & b_eff_w;
  assign or_w    = a_i | b_eff_w;
  assign sum_o   = fa_sum(a_i, b_eff_w, cin_i);
  assign cout_o  = fa_carry(a_i, b_eff_w, cin_i);
  assign res_o   = fn_pick(fn_i, and_w, or_w, sum_o, less_i);

endmodule

// File: rtl/alu_msb_flags.sv
module alu_msb_flags
  import alu_slice_pkg::*;
(
  input  logic cin_i,
  input  logic cout_i,
  input  logic sum_i,
  output logic set_o,
  output logic ovf_o
);

  logic ovf_w;

  assign ovf_w = top_overflow(cin_i, cout_i);
  // true sign of the arithmetic result, corrected when the top bit wrapped
  assign set_o = sum_i ^ ovf_w;
  assign ovf_o = ovf_w;

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic             zero_o
);

  localparam int GROUP  = 4;
  localparam int NGROUP = (WIDTH + GROUP - 1) / GROUP;
  localparam int PADW   = NGROUP * GROUP;

  logic [PADW-1:0]   pad_w;
  logic [NGROUP-1:0] grp_any_w;

  assign pad_w = {{(PADW-WIDTH){1'b0}}, vec_i};

  for (genvar g = 0; g < NGROUP; g++) begin : g_grp
    assign grp_any_w[g] = |pad_w[g*GROUP +: GROUP];
  end

  assign zero_o = ~|grp_any_w;

endmodule

// File: rtl/slt_alu.sv
module slt_alu
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       op_i,
  input  logic             b_inv_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o
);

  localparam int MSB = WIDTH - 1;

  alu_fn_e          fn_w;
  logic [WIDTH-1:0] res_w;
  logic [WIDTH-1:0] sum_w;
  logic             set_w;
  logic             msb_cin_w;
  logic             msb_cout_w;

  assign fn_w = alu_fn_e'(op_i);

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic cin_w;
    logic cout_w;
    logic less_w;
    if (i == 0) begin : g_lsb
      assign cin_w  = b_inv_i;
      assign less_w = set_w;
    end else begin : g_upper
      assign cin_w  = g_slice[i-1].cout_w;
      assign less_w = 1'b0;
    end
    alu_bit_slice u_slice (
      .a_i    (a_i[i]),
      .b_i    (b_i[i]),
      .b_inv_i(b_inv_i),
      .cin_i  (cin_w),
      .less_i (less_w),
      .fn_i   (fn_w),
      .res_o  (res_w[i]),
      .sum_o  (sum_w[i]),
      .cout_o (cout_w)
    );
  end

  assign msb_cin_w  = g_slice[MSB].cin_w;
  assign msb_cout_w = g_slice[MSB].cout_w;

  alu_msb_flags u_flags (
    .cin_i (msb_cin_w),
    .cout_i(msb_cout_w),
    .sum_i (sum_w[MSB]),
    .set_o (set_w),
    .ovf_o (ovf_o)
  );

  alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .vec_i (res_w),
    .zero_o(zero_o)
  );

  assign result_o = res_w;

endmodule

// File: rtl/slt_alu_checker.sv
module slt_alu_checker #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [1:0]       op_i,
  input logic             b_inv_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             ovf_o,
  input logic             set_w
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] beff;
  logic [WIDTH-1:0] arith;
  logic             known;

  always_comb begin
    beff  = b_inv_i ? ~b_i : b_i;
    arith = a_i + beff + {{(WIDTH-1){1'b0}}, b_inv_i};
    known = !$isunknown({a_i, b_i, op_i, b_inv_i, result_o, zero_o, ovf_o, set_w});
    if (known) begin
      // R1 / R5: AND against effective operand
      p_and_r1: assert (op_i != 2'd0 || result_o == (a_i & beff));
      // R2
      p_or_r2: assert (op_i != 2'd1 || result_o == (a_i | beff));
      // R3
      p_add_r3: assert (!(op_i == 2'd2 && !b_inv_i) || result_o == a_i + b_i);
      // R4
      p_sub_r4: assert (!(op_i == 2'd2 && b_inv_i) || result_o == a_i - b_i);
      // R6
      p_zero_r6: assert (zero_o == (result_o == '0));
      // R7: sign of operands alike and sign of result differs
      p_ovf_r7: assert (ovf_o == ((a_i[MSB] == beff[MSB]) && (arith[MSB] != a_i[MSB])));
      // R8
      p_slt_r8: assert (!(op_i == 2'd3 && b_inv_i) ||
                        result_o[0] == ($signed(a_i) < $signed(b_i)));
      // R9
      p_slt_upper_r9: assert (op_i != 2'd3 || result_o[MSB:1] == '0);
      // R8: fed-back bit matches bit 0 in the less function
      p_set_feed_r8: assert (op_i != 2'd3 || result_o[0] == set_w);
    end
  end

endmodule

bind slt_alu slt_alu_checker #(.WIDTH(WIDTH)) u_slt_alu_checker (
  .a_i     (a_i),
  .b_i     (b_i),
  .op_i    (op_i),
  .b_inv_i (b_inv_i),
  .result_o(result_o),
  .zero_o  (zero_o),
  .ovf_o   (ovf_o),
  .set_w   (set_w)
);

// File: tb/test_slt_alu.sv
module test_slt_alu;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [1:0]   op = 2'd0;
  logic         binv = 1'b0;
  logic [W-1:0] result;
  logic         zero;
  logic         ovf;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  slt_alu #(.WIDTH(W)) i_slt_alu (
    .a_i(a), .b_i(b), .op_i(op), .b_inv_i(binv),
    .result_o(result), .zero_o(zero), .ovf_o(ovf)
  );

  // independent reference: widen and compute with integer arithmetic
  task automatic model(input logic [W-1:0] xa, input logic [W-1:0] xb,
                       input logic [1:0] xop, input logic xinv,
                       output logic [W-1:0] er, output logic eo);
    logic [W-1:0]      bb;
    logic signed [W+1:0] full;
    logic [W-1:0]      wrap;
    bb   = xinv ? ~xb : xb;
    full = $signed({{2{xa[W-1]}}, xa}) + $signed({{2{bb[W-1]}}, bb}) + xinv;
    wrap = full[W-1:0];
    eo   = (full > $signed({3'b000, {(W-1){1'b1}}})) || (full < -$signed({2'b00, 1'b1, {(W-1){1'b0}}}));
    case (xop)
      2'd0: er = xa & bb;
      2'd1: er = xa | bb;
      2'd2: er = wrap;
      default: er = {{(W-1){1'b0}}, full < 0};
    endcase
  endtask

  task automatic apply_check(input string req, input logic [W-1:0] xa,
                             input logic [W-1:0] xb, input logic [1:0] xop,
                             input logic xinv);
    logic [W-1:0] er;
    logic         eo;
    @(negedge clk);
    a = xa; b = xb; op = xop; binv = xinv;
    #1;
    model(xa, xb, xop, xinv, er, eo);
    n_cmp++;
    if (result !== er) begin
      n_bad++;
      $display("FAIL %s result: actual %h expected %h", req, result, er);
    end
    n_cmp++;
    if (zero !== (er == '0)) begin
      n_bad++;
      $display("FAIL R6 (%s) zero: actual %b expected %b", req, zero, er == '0);
    end
    n_cmp++;
    if (ovf !== eo) begin
      n_bad++;
      $display("FAIL R7 (%s) overflow: actual %b expected %b", req, ovf, eo);
    end
  endtask

  task automatic t_idle();
    // all-zero inputs: AND of zeros gives zero result, zero flag, no overflow
    apply_check("R6", '0, '0, 2'd0, 1'b0);
  endtask

  task automatic t_logic();
    apply_check("R1", 32'hF0F0_1234, 32'hFF00_FF0F, 2'd0, 1'b0);
    apply_check("R2", 32'h0F00_0001, 32'h00F0_8000, 2'd1, 1'b0);
    apply_check("R5", 32'hFFFF_0000, 32'h0F0F_0F0F, 2'd0, 1'b1);
    apply_check("R5", 32'h0000_0000, 32'hFFFF_FFFE, 2'd1, 1'b1);
  endtask

  task automatic t_add();
    apply_check("R3", 32'd1234, 32'd4321, 2'd2, 1'b0);
    apply_check("R3", 32'h7FFF_FFFF, 32'd1, 2'd2, 1'b0);
    apply_check("R3", 32'hFFFF_FFFF, 32'd1, 2'd2, 1'b0);
    apply_check("R7", 32'h8000_0000, 32'h8000_0000, 2'd2, 1'b0);
  endtask

  task automatic t_sub();
    apply_check("R4", 32'd100, 32'd100, 2'd2, 1'b1);
    apply_check("R4", 32'd5, 32'd9, 2'd2, 1'b1);
    apply_check("R7", 32'h8000_0000, 32'd1, 2'd2, 1'b1);
    apply_check("R7", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 2'd2, 1'b1);
  endtask

  task automatic t_slt();
    apply_check("R8", 32'd3, 32'd7, 2'd3, 1'b1);
    apply_check("R8", 32'd7, 32'd3, 2'd3, 1'b1);
    apply_check("R8", 32'hFFFF_FFFF, 32'd0, 2'd3, 1'b1);
    apply_check("R8", 32'd9, 32'd9, 2'd3, 1'b1);
    apply_check("R8", 32'h8000_0000, 32'd1, 2'd3, 1'b1);
    apply_check("R8", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 2'd3, 1'b1);
    apply_check("R9", 32'hC000_0000, 32'h4000_0000, 2'd3, 1'b1);
    apply_check("R9", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd3, 1'b0);
  endtask

  task automatic t_sweep();
    logic [W-1:0] s;
    s = 32'h1357_9BDF;
    for (int k = 0; k < 40; k++) begin
      s = {s[W-2:0], s[W-1] ^ s[21] ^ s[1] ^ s[0]};
      apply_check("R3", s, {s[15:0], s[W-1:16]}, k[1:0], k[2]);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_idle();
    t_logic();
    t_add();
    t_sub();
    t_slt();
    t_sweep();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule